// File: doc/BRIEF.md
# Lane-Striped Reorder Buffer

This block is a reorder buffer built from four stripes that have no connection to one another. Each entry number has two parts: its low two bits name the lane and its upper bits name a slot inside that lane's stripe. An instruction must take an entry in the lane given by the low two bits of its destination register. As a result, a stripe never holds an instruction that writes a register from another lane. Each stripe is a ring that fills in order. It keeps a completion flag per slot. It can be searched by destination register, and the search compares only the destination bits above the lane bits.

Each lane has its own allocation port, so up to four instructions can enter in one cycle when they target different lanes. When several enter together, a lower port index means an older instruction. Each allocation is stamped with a global sequence number. Retirement takes one instruction per cycle: the one whose stamp is next in program order, once it is complete. It reports the entry, the full destination and the result value. Lanes that received nothing during a run of same-lane instructions hold no entries for those sequence numbers. Retirement therefore moves past those holes with no idle cycles.

A completion port writes a result into an entry by entry number and marks the entry complete. A lookup port reports whether a destination register has an entry in flight. If it does, the port returns the youngest such entry and its completion flag.

Top module: `stripe_rob`

## Requirements
- R1: While reset is held, and in the first cycle after it, every bit of `alloc_ready` is 1, `ret_valid` is 0 and `look_hit` is 0. The buffer is then empty.
- R2: The entry number offered on allocation port k is {slot, k} (slot in bits 4:2, lane in bits 1:0). Within a lane, slots are handed out in ring order starting at slot 0 after reset.
- R3: An allocation on port k is taken only when bits 1:0 of its destination equal k. A refused request consumes no slot, leaves the offered entry number unchanged, and cannot be found by lookup.
- R4: `alloc_ready[k]` is 0 exactly when lane k holds 8 entries. A full lane refuses allocations while the other lanes stay ready.
- R5: Requests on all four ports in one cycle are all taken. Their program order is ascending port index, and they retire in that order.
- R6: A completion sets the done flag of an occupied entry and stores its value; the flag is visible on `look_done`. An entry retires only while its done flag is set. A completion to an unoccupied entry produces no retirement.
- R7: Retirement follows allocation order across all lanes. A younger completed entry waits while an older one is incomplete. At most one entry retires per cycle, and the retirement outputs show its entry number, full 8-bit destination and value.
- R8: A lookup searches only the lane named by bits 1:0 of `look_dest` and compares bits 7:2 (bit 7 selects integer or floating point). Among several matches it returns the youngest occupied entry.
- R9: Once the oldest entries are complete, retirement runs one entry per cycle with no idle cycle, even when consecutive instructions share a lane and leave holes in the other lanes.
- R10: `alloc_ready` reflects occupancy at the start of the cycle. A slot freed by a retirement can be allocated from the next cycle on. An allocation and a retirement in the same lane in the same cycle leave that lane's occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 4 | Allocation request, one bit per lane port |
| alloc_dest | input | 32 | Destination per port, 8 bits each, port k in bits 8k+7:8k |
| alloc_ready | output | 4 | Lane has a free slot |
| alloc_entry | output | 20 | Entry number offered per port, 5 bits each |
| cmp_valid | input | 1 | Completion strobe |
| cmp_entry | input | 5 | Entry being completed |
| cmp_data | input | 32 | Result value |
| look_dest | input | 8 | Destination register to search for |
| look_hit | output | 1 | An occupied entry matches |
| look_entry | output | 5 | Youngest matching entry |
| look_done | output | 1 | Done flag of that entry |
| ret_valid | output | 1 | An entry retires at this clock edge |
| ret_entry | output | 5 | Retiring entry number |
| ret_dest | output | 8 | Retiring destination |
| ret_data | output | 32 | Retiring value |

## Verification
Two functions can meet in the same lane in one cycle: retirement of a stripe's head and allocation into that stripe's tail. The bench first fills one lane and completes its two oldest entries back to back. In the cycle the second of them retires, it drives a new allocation into the slot the first one freed. The test passes if the lane refuses allocation during the cycle in which it is still full, accepts the new entry in the ring slot that was just vacated, and shows unchanged occupancy and the correct next entry number afterwards. Lookup must then find the new entry.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
// Package rob_pkg: default geometry shared by the striped reorder buffer
// and its checker. Assumes lane and slot counts are powers of two.
package rob_pkg;
    localparam int ROB_LANES  = 4;   // independent stripes
    localparam int ROB_DEPTH  = 8;   // slots per stripe
    localparam int ROB_TAG_W  = 8;   // class bit plus 7-bit register number
    localparam int ROB_DATA_W = 32;  // result width
endpackage

// File: rtl/rob_stripe.sv
`timescale 1ns/1ps
// rob_stripe: one lane of the buffer. A ring of DEPTH slots filled at the
// tail and drained at the head, with a done flag per slot and a lookup
// on the reduced destination key. Assumes DEPTH is a power of two and that
// alloc_en is only raised while has_room is set.
module rob_stripe #(
    parameter int DEPTH  = 8,
    parameter int KEY_W  = 6,
    parameter int DATA_W = 32,
    parameter int SEQ_W  = 6,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [KEY_W-1:0]  alloc_key,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              cmp_en,
    input  logic [SLOT_W-1:0] cmp_slot,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic              retire_en,
    input  logic [KEY_W-1:0]  look_key,
    output logic              has_room,
    output logic [SLOT_W-1:0] tail_slot,
    output logic              head_valid,
    output logic              head_done,
    output logic [SEQ_W-1:0]  head_seq,
    output logic [KEY_W-1:0]  head_key,
    output logic [DATA_W-1:0] head_data,
    output logic [SLOT_W-1:0] head_slot,
    output logic              look_hit,
    output logic              look_done,
    output logic [SLOT_W-1:0] look_slot
);
    logic [SLOT_W-1:0] head_q;
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  done_q;
    logic [DEPTH-1:0]  live;
    logic [KEY_W-1:0]  key_q  [DEPTH];
    logic [SEQ_W-1:0]  seq_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    assign has_room   = (count_q < CNT_W'(DEPTH));
    assign tail_slot  = head_q + SLOT_W'(count_q);
    assign head_valid = (count_q != '0);
    assign head_slot  = head_q;
    assign head_done  = done_q[head_q];
    assign head_seq   = seq_q[head_q];
    assign head_key   = key_q[head_q];
    assign head_data  = data_q[head_q];

    // Occupancy map: a slot is live when it lies within count of the head.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            live[i] = (CNT_W'(SLOT_W'(i) - head_q) < count_q);
        end
    end

    // Ring pointers and done flags, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
            done_q  <= '0;
        end else begin
            if (retire_en) head_q <= head_q + 1'b1;
            count_q <= count_q + CNT_W'(alloc_en) - CNT_W'(retire_en);
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_en && tail_slot == SLOT_W'(i))
                    done_q[i] <= 1'b0;
                else if (cmp_en && cmp_slot == SLOT_W'(i) && live[i])
                    done_q[i] <= 1'b1;
            end
        end
    end

    // Slot payload: key and stamp at allocation, value at completion.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            key_q[tail_slot] <= alloc_key;
            seq_q[tail_slot] <= alloc_seq;
        end
        if (cmp_en && live[cmp_slot]) data_q[cmp_slot] <= cmp_data;
    end

    // Key search from oldest to youngest; the last match found wins.
    always_comb begin
        look_hit  = 1'b0;
        look_slot = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [SLOT_W-1:0] idx;
            idx = head_q + SLOT_W'(k);
            if (CNT_W'(k) < count_q && key_q[idx] == look_key) begin
                look_hit  = 1'b1;
                look_slot = idx;
            end
        end
        look_done = look_hit && done_q[look_slot];
    end
endmodule

// File: rtl/rob_seq_assign.sv
`timescale 1ns/1ps
// rob_seq_assign: stamps each accepted allocation with a program-order
// number. Lower port index is older within a cycle. Assumes at most
// 2**(SEQ_W-1) instructions are in flight so stamps stay unique.
module rob_seq_assign #(
    parameter int LANES = 4,
    parameter int SEQ_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       accept,
    output logic [LANES*SEQ_W-1:0] seq
);
    logic [SEQ_W-1:0] base_q;
    logic [SEQ_W-1:0] next_base;

    // Prefix count over accepted ports gives each its stamp.
    always_comb begin
        next_base = base_q;
        for (int k = 0; k < LANES; k++) begin
            seq[k*SEQ_W +: SEQ_W] = next_base;
            next_base = next_base + SEQ_W'(accept[k]);
        end
    end

    // Stamp counter advances by the number accepted this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= next_base;
    end
endmodule

// File: rtl/rob_retire_sel.sv
`timescale 1ns/1ps
// rob_retire_sel: keeps the stamp of the next instruction to retire and
// picks the stripe whose head carries that stamp once it is done. Assumes
// every stamp handed out is retired exactly once, in order.
module rob_retire_sel #(
    parameter int LANES = 4,
    parameter int SEQ_W = 6,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       head_valid,
    input  logic [LANES-1:0]       head_done,
    input  logic [LANES*SEQ_W-1:0] head_seq,
    output logic [LANES-1:0]       retire_en,
    output logic                   retire_any,
    output logic [LANE_W-1:0]      retire_lane
);
    logic [SEQ_W-1:0] next_q;

    // Match the expected stamp against every stripe head.
    always_comb begin
        retire_en   = '0;
        retire_lane = '0;
        for (int k = 0; k < LANES; k++) begin
            if (head_valid[k] && head_done[k] &&
                head_seq[k*SEQ_W +: SEQ_W] == next_q) begin
                retire_en[k] = 1'b1;
                retire_lane  = LANE_W'(k);
            end
        end
        retire_any = |retire_en;
    end

    // Expected stamp steps on each retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) next_q <= '0;
        else        next_q <= next_q + SEQ_W'(retire_any);
    end
endmodule

// File: rtl/stripe_rob.sv
`timescale 1ns/1ps
// stripe_rob: reorder buffer of LANES independent stripes. Entry number is
// {slot, lane}; port k only accepts destinations whose low lane bits are k.
// Retires one complete instruction per cycle in program order. Assumes the
// caller presents same-cycle requests in program order by port index.
module stripe_rob import rob_pkg::*; #(
    parameter int LANES  = ROB_LANES,
    parameter int DEPTH  = ROB_DEPTH,
    parameter int TAG_W  = ROB_TAG_W,
    parameter int DATA_W = ROB_DATA_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int ENT_W  = LANE_W + SLOT_W,
    localparam int KEY_W  = TAG_W - LANE_W,
    localparam int SEQ_W  = ENT_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       alloc_valid,
    input  logic [LANES*TAG_W-1:0] alloc_dest,
    output logic [LANES-1:0]       alloc_ready,
    output logic [LANES*ENT_W-1:0] alloc_entry,
    input  logic                   cmp_valid,
    input  logic [ENT_W-1:0]       cmp_entry,
    input  logic [DATA_W-1:0]      cmp_data,
    input  logic [TAG_W-1:0]       look_dest,
    output logic                   look_hit,
    output logic [ENT_W-1:0]       look_entry,
    output logic                   look_done,
    output logic                   ret_valid,
    output logic [ENT_W-1:0]       ret_entry,
    output logic [TAG_W-1:0]       ret_dest,
    output logic [DATA_W-1:0]      ret_data
);
    logic [LANES-1:0]       accept;
    logic [LANES*SEQ_W-1:0] seq;
    logic [LANES-1:0]       room, h_valid, h_done, retire_en, l_hit, l_done;
    logic [LANES*SEQ_W-1:0] h_seq;
    logic [SLOT_W-1:0]      tail [LANES];
    logic [SLOT_W-1:0]      h_slot [LANES];
    logic [SLOT_W-1:0]      l_slot [LANES];
    logic [KEY_W-1:0]       h_key [LANES];
    logic [DATA_W-1:0]      h_data [LANES];
    logic                   retire_any;
    logic [LANE_W-1:0]      retire_lane;
    logic [LANE_W-1:0]      look_lane;

    assign look_lane = look_dest[LANE_W-1:0];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            // Port k is taken only with room and a destination in lane k.
            assign accept[k] = alloc_valid[k] && room[k] &&
                (alloc_dest[k*TAG_W +: LANE_W] == LANE_W'(k));
            assign alloc_ready[k] = room[k];
            assign alloc_entry[k*ENT_W +: ENT_W] = {tail[k], LANE_W'(k)};

            rob_stripe #(
                .DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)
            ) u_stripe (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc_en   (accept[k]),
                .alloc_key  (alloc_dest[k*TAG_W+LANE_W +: KEY_W]),
                .alloc_seq  (seq[k*SEQ_W +: SEQ_W]),
                .cmp_en     (cmp_valid && cmp_entry[LANE_W-1:0] == LANE_W'(k)),
                .cmp_slot   (cmp_entry[ENT_W-1:LANE_W]),
                .cmp_data   (cmp_data),
                .retire_en  (retire_en[k]),
                .look_key   (look_dest[TAG_W-1:LANE_W]),
                .has_room   (room[k]),
                .tail_slot  (tail[k]),
                .head_valid (h_valid[k]),
                .head_done  (h_done[k]),
                .head_seq   (h_seq[k*SEQ_W +: SEQ_W]),
                .head_key   (h_key[k]),
                .head_data  (h_data[k]),
                .head_slot  (h_slot[k]),
                .look_hit   (l_hit[k]),
                .look_done  (l_done[k]),
                .look_slot  (l_slot[k])
            );
        end
    endgenerate

    rob_seq_assign #(.LANES(LANES), .SEQ_W(SEQ_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .seq    (seq)
    );

    rob_retire_sel #(.LANES(LANES), .SEQ_W(SEQ_W)) u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_valid  (h_valid),
        .head_done   (h_done),
        .head_seq    (h_seq),
        .retire_en   (retire_en),
        .retire_any  (retire_any),
        .retire_lane (retire_lane)
    );

    // Retirement outputs rebuild the full destination from key and lane.
    assign ret_valid = retire_any;
    assign ret_entry = {h_slot[retire_lane], retire_lane};
    assign ret_dest  = {h_key[retire_lane], retire_lane};
    assign ret_data  = h_data[retire_lane];

    // Lookup result comes from the lane named by the destination.
    assign look_hit   = l_hit[look_lane];
    assign look_done  = l_done[look_lane];
    assign look_entry = {l_slot[look_lane], look_lane};
endmodule

// File: rtl/stripe_rob_chk.sv
`timescale 1ns/1ps
// stripe_rob_chk: port-level model of occupancy and done flags, used to
// check the buffer's stall, retirement and lookup outputs. Bound to
// stripe_rob below.
module stripe_rob_chk #(
    parameter int LANES  = 4,
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32,
    localparam int LANE_W = $clog2(LANES),
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int ENT_W  = LANE_W + SLOT_W,
    localparam int NENT   = LANES * DEPTH,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       alloc_valid,
    input logic [LANES*TAG_W-1:0] alloc_dest,
    input logic [LANES-1:0]       alloc_ready,
    input logic [LANES*ENT_W-1:0] alloc_entry,
    input logic                   cmp_valid,
    input logic [ENT_W-1:0]       cmp_entry,
    input logic [TAG_W-1:0]       look_dest,
    input logic                   look_hit,
    input logic [ENT_W-1:0]       look_entry,
    input logic                   ret_valid,
    input logic [ENT_W-1:0]       ret_entry
);
    logic [NENT-1:0]  inuse, cdone;
    logic [CNT_W-1:0] occ [LANES];
    logic [LANES-1:0] took;

    // Model of which requests the block should have accepted.
    always_comb begin
        for (int k = 0; k < LANES; k++)
            took[k] = alloc_valid[k] && alloc_ready[k] &&
                (alloc_dest[k*TAG_W +: LANE_W] == LANE_W'(k));
    end

    // Track occupancy and completion per entry from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inuse <= '0;
            cdone <= '0;
        end else begin
            if (ret_valid) inuse[ret_entry] <= 1'b0;
            if (cmp_valid && inuse[cmp_entry]) cdone[cmp_entry] <= 1'b1;
            for (int k = 0; k < LANES; k++) begin
                if (took[k]) begin
                    inuse[alloc_entry[k*ENT_W +: ENT_W]] <= 1'b1;
                    cdone[alloc_entry[k*ENT_W +: ENT_W]] <= 1'b0;
                end
            end
        end
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_occ
            // Per-lane entry count from accepts and retirements.
            always_ff @(posedge clk) begin
                if (!rst_n) occ[k] <= '0;
                else occ[k] <= occ[k] + CNT_W'(took[k]) -
                    CNT_W'(ret_valid && ret_entry[LANE_W-1:0] == LANE_W'(k));
            end

            a_r4_ready_tracks_fill: assert property (@(posedge clk) disable iff (!rst_n)
                alloc_ready[k] == (occ[k] < CNT_W'(DEPTH)));
        end
    endgenerate

    a_r6_retire_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> cdone[ret_entry]);

    a_r7_retire_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> inuse[ret_entry]);

    a_r7_no_double_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && $past(ret_valid)) |-> (ret_entry != $past(ret_entry)));

    a_r8_hit_in_lane: assert property (@(posedge clk) disable iff (!rst_n)
        look_hit |-> (inuse[look_entry] &&
            look_entry[LANE_W-1:0] == look_dest[LANE_W-1:0]));
endmodule

bind stripe_rob stripe_rob_chk #(
    .LANES(LANES), .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_dest  (alloc_dest),
    .alloc_ready (alloc_ready),
    .alloc_entry (alloc_entry),
    .cmp_valid   (cmp_valid),
    .cmp_entry   (cmp_entry),
    .look_dest   (look_dest),
    .look_hit    (look_hit),
    .look_entry  (look_entry),
    .ret_valid   (ret_valid),
    .ret_entry   (ret_entry)
);

// File: tb/stripe_rob_tb.sv
`timescale 1ns/1ps
// stripe_rob_tb: table-driven allocation, completion and retirement,
// then directed tests for reset, lane refusal, full lanes and overlap.
module stripe_rob_tb;
    localparam int LANES = 4, TAG_W = 8, ENT_W = 5, DATA_W = 32;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic [LANES-1:0]       alloc_valid;
    logic [LANES*TAG_W-1:0] alloc_dest;
    logic [LANES-1:0]       alloc_ready;
    logic [LANES*ENT_W-1:0] alloc_entry;
    logic                   cmp_valid;
    logic [ENT_W-1:0]       cmp_entry;
    logic [DATA_W-1:0]      cmp_data;
    logic [TAG_W-1:0]       look_dest;
    logic                   look_hit, look_done, ret_valid;
    logic [ENT_W-1:0]       look_entry, ret_entry;
    logic [TAG_W-1:0]       ret_dest;
    logic [DATA_W-1:0]      ret_data;

    int n_chk = 0, n_fail = 0, cycles = 0;

    // {destination, expected entry}, in program order
    localparam logic [12:0] VEC [9] = '{
        {8'h01, 5'd1},  {8'h05, 5'd5},  {8'h82, 5'd2},
        {8'h09, 5'd9},  {8'h43, 5'd3},  {8'h80, 5'd0},
        {8'h06, 5'd6},  {8'h85, 5'd13}, {8'h05, 5'd17}
    };

    stripe_rob u_dut (.*);

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        alloc_valid = '0; alloc_dest = '0; cmp_valid = 1'b0;
        cmp_entry = '0; cmp_data = '0;
    endtask

    task automatic put(int p, logic [7:0] d);
        alloc_valid[p] = 1'b1;
        alloc_dest[p*TAG_W +: TAG_W] = d;
    endtask

    task automatic complete(logic [4:0] e, logic [31:0] v);
        cmp_valid = 1'b1; cmp_entry = e; cmp_data = v;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle(); look_dest = 8'h00;
        tick(); tick(); tick();
        check("R1 ready in reset", 32'(alloc_ready), 32'hF);
        check("R1 ret_valid in reset", 32'(ret_valid), 0);
        check("R1 look_hit in reset", 32'(look_hit), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        #1;
        check("R1 ready after reset", 32'(alloc_ready), 32'hF);

        // Table walk: one allocation per cycle on the destination's lane port.
        #1;
        tick();
        for (int i = 0; i < 9; i++) begin
            logic [7:0] d;
            logic [4:0] e;
            d = VEC[i][12:5]; e = VEC[i][4:0];
            put(int'(d[1:0]), d);
            #1;
            check("R2 entry number", 32'(alloc_entry[d[1:0]*ENT_W +: ENT_W]), 32'(e));
            check("R4 ready while not full", 32'(alloc_ready), 32'hF);
            tick(); idle();
        end

        // R8 lookups: youngest match, class bit distinguishes, misses.
        look_dest = 8'h05; #1;
        check("R8 youngest hit", 32'(look_hit), 1);
        check("R8 youngest entry", 32'(look_entry), 17);
        tick(); look_dest = 8'h85; #1;
        check("R8 class bit entry", 32'(look_entry), 13);
        tick(); look_dest = 8'h0D; #1;
        check("R8 miss", 32'(look_hit), 0);
        tick(); look_dest = 8'h05;

        // Complete youngest first: nothing may retire yet (R7).
        for (int i = 8; i >= 1; i--) begin
            complete(VEC[i][4:0], 32'hA000 + 32'(i));
            #1;
            check("R7 no retire before oldest", 32'(ret_valid), 0);
            if (i == 7) check("R6 look_done after completion", 32'(look_done), 1);
            tick();
        end
        complete(VEC[0][4:0], 32'hA000);
        tick(); idle();
        // R9: back-to-back retirement in program order across holes.
        for (int i = 0; i < 9; i++) begin
            if (i > 0) tick();
            #1;
            check("R9 retire each cycle", 32'(ret_valid), 1);
            check("R7 retire entry", 32'(ret_entry), 32'(VEC[i][4:0]));
            check("R7 retire dest", 32'(ret_dest), 32'(VEC[i][12:5]));
            check("R7 retire data", ret_data, 32'hA000 + 32'(i));
        end
        tick(); #1;
        check("R7 drained", 32'(ret_valid), 0);

        // R6: completion to an unoccupied entry is ignored.
        tick();
        complete(5'd4, 32'hDEAD);
        tick(); idle(); #1;
        check("R6 stray completion no retire", 32'(ret_valid), 0);
        put(0, 8'h80); #1;
        check("R6 next lane0 entry", 32'(alloc_entry[4:0]), 4);
        tick(); idle(); look_dest = 8'h80; #1;
        check("R6 fresh entry not done", 32'(look_done), 0);
        check("R6 fresh entry hit", 32'(look_entry), 4);

        // R3: wrong-lane request on port 0 is refused.
        tick();
        put(0, 8'h81);
        tick(); idle(); look_dest = 8'h81; #1;
        check("R3 refused not found", 32'(look_hit), 0);
        check("R3 port0 entry unchanged", 32'(alloc_entry[4:0]), 8);
        check("R3 port1 entry unchanged", 32'(alloc_entry[9:5]), 21);

        // R1 again, then R5: four lanes in one cycle.
        tick();
        do_reset();
        for (int p = 0; p < 4; p++) put(p, 8'h10 + 8'(p));
        #1;
        check("R5 four entries offered", 32'(alloc_entry), {12'd0, 5'd3, 5'd2, 5'd1, 5'd0});
        tick(); idle();
        for (int e = 3; e >= 1; e--) begin
            complete(5'(e), 32'hB000 + 32'(e));
            #1;
            check("R5 wait for port0 entry", 32'(ret_valid), 0);
            tick();
        end
        complete(5'd0, 32'hB000);
        tick(); idle();
        for (int e = 0; e < 4; e++) begin
            if (e > 0) tick();
            #1;
            check("R5 port order retire", 32'(ret_entry), 32'(e));
            check("R5 retire dest", 32'(ret_dest), 32'h10 + 32'(e));
        end

        // R4 and R10: fill lane 2, then overlap retire with allocate.
        tick();
        do_reset();
        for (int i = 0; i < 8; i++) begin
            put(2, 8'h02 + 8'(4 * i));
            tick(); idle();
        end
        #1;
        check("R4 only full lane stalls", 32'(alloc_ready), 32'hB);
        put(2, 8'h22);
        tick(); idle(); look_dest = 8'h22; #1;
        check("R4 refused while full", 32'(look_hit), 0);
        complete(5'd2, 32'hC002);
        tick();
        complete(5'd6, 32'hC006); #1;
        check("R10 retiring head", 32'(ret_entry), 2);
        check("R10 still full this cycle", 32'(alloc_ready[2]), 0);
        tick(); idle();
        put(2, 8'h7E); #1;
        check("R10 ready after retire", 32'(alloc_ready[2]), 1);
        check("R10 freed slot offered", 32'(alloc_entry[14:10]), 2);
        check("R10 second retire", 32'(ret_entry), 6);
        tick(); idle(); look_dest = 8'h7E; #1;
        check("R10 occupancy unchanged", 32'(alloc_ready[2]), 1);
        check("R10 next ring slot", 32'(alloc_entry[14:10]), 6);
        check("R10 no retire pending", 32'(ret_valid), 0);
        check("R10 new entry found", 32'(look_entry), 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule